// File: doc/BRIEF.md
# Memory Operation Issue Gate

This block sits beside the unified issue and reorder buffer of an out-of-order core. Every clock it decides which pending memory operations may be sent to memory. A load to ordinary memory has no side effects. It may go ahead of older work once an address check shows that no older store still in flight can write the word it reads. Stores, and any access that falls inside the memory-mapped peripheral window, are held back until their entry is the oldest one in the buffer.

The buffer is circular. For each entry the block receives the operation kind, the address, and a flag that says whether the address is known yet. It also receives a head pointer that marks the oldest entry. The age of each entry is measured from the head, so the check still works after the buffer index wraps around. When a store commits, its entry stops presenting a store. Any load it was blocking then becomes eligible. The result is a registered permit vector with one bit per entry.

Top module: `memOrderGate`

## Requirements
- R1: While reset is asserted, whether applied at start-up or in the middle of a run, the permit vector is all zeros.
- R2: An entry whose operation code is 2'b00 (empty) or 2'b11 (reserved), or whose address-known flag is low, never receives a permit. The codes are 2'b01 for a load and 2'b10 for a store.
- R3: The entry at the head pointer, holding a load or a store with a known address, is always permitted. This holds inside or outside the peripheral window.
- R4: A store that is not at the head pointer is never permitted.
- R5: A load not at the head pointer whose address lies in the peripheral window is not permitted. The window is [IO_BASE, IO_LAST], with both bounds inclusive.
- R6: A load outside the window is permitted when no older store is present. Stores that are younger than the load, even at the same address, do not hold it back. Once a blocking store's entry is emptied (committed), the load is permitted.
- R7: A load not at the head is held while any older store still has an unknown address.
- R8: Addresses are compared on 8-byte words (address bits above bit 2). An older store in the same word blocks a load even when the byte offsets differ. An older store in a different word does not block it.
- R9: Age is (index - headPtr) modulo ENTRIES. An entry at a lower index than the head is younger than every entry from the head upward.
- R10: The permit vector is registered: it reflects the inputs present before the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| entryOp | input | ENTRIES x 2 | Per-entry operation code (00 empty, 01 load, 10 store, 11 reserved) |
| entryAddr | input | ENTRIES x ADDR_W | Per-entry byte address |
| entryAddrOk | input | ENTRIES | Per-entry address-known flag |
| headPtr | input | log2(ENTRIES) | Index of the oldest buffer entry |
| issueOk | output | ENTRIES | Per-entry permission to issue to memory |

## Verification
Each permit bit is due exactly one rising edge after the inputs it depends on. The driver changes the buffer contents on a falling edge and pushes the hand-derived permit vector into a queue. The monitor pops that vector 1 ns after the next rising edge and compares it with issueOk, so each stimulus is judged against the cycle its result belongs to. The reset checks are different: they sample the output directly while reset is held, because the clear does not wait for a clock.

// File: rtl/memorder_pkg.sv
package memorder_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_RSVD  = 2'b11
  } memOp_e;

  // Per-entry strobes handed from control to datapath.
  typedef struct packed {
    logic isHead;
    logic isLoad;
    logic isStore;
  } entryStrobe_t;

endpackage

// File: rtl/memOrderCtrl.sv
module memOrderCtrl
  import memorder_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][1:0]         entryOp,
  input  logic [IDX_W-1:0]                headPtr,
  output entryStrobe_t [ENTRIES-1:0]      strobes,
  output logic [ENTRIES-1:0][ENTRIES-1:0] olderMask
);

  logic [ENTRIES-1:0][IDX_W-1:0] entryAge;

  // Age counts from the head; the index arithmetic wraps by width.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_age
    assign entryAge[i]          = IDX_W'(i) - headPtr;
    assign strobes[i].isHead    = (entryAge[i] == '0);
    assign strobes[i].isLoad    = (entryOp[i] == OP_LOAD);
    assign strobes[i].isStore   = (entryOp[i] == OP_STORE);
  end

  // olderMask[i][j] is set when entry j is older than entry i.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_row
    for (genvar j = 0; j < ENTRIES; j++) begin : g_col
      assign olderMask[i][j] = (entryAge[j] < entryAge[i]);
    end
  end

endmodule

// File: rtl/memOrderPath.sv
module memOrderPath
  import memorder_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W = 32,
  parameter int WORD_SHIFT = 3,
  parameter logic [ADDR_W-1:0] IO_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] IO_LAST = 32'h4FFF_FFFF,
  localparam int TAG_W = ADDR_W - WORD_SHIFT
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  entryStrobe_t [ENTRIES-1:0]      strobes,
  input  logic [ENTRIES-1:0][ENTRIES-1:0] olderMask,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]  entryAddr,
  input  logic [ENTRIES-1:0]              entryAddrOk,
  output logic [ENTRIES-1:0]              issueOk
);

  logic [ENTRIES-1:0][TAG_W-1:0]   wordTag;
  logic [ENTRIES-1:0]              ioHit;
  logic [ENTRIES-1:0]              storeVec;
  logic [ENTRIES-1:0][ENTRIES-1:0] hazard;
  logic [ENTRIES-1:0]              blocked;
  logic [ENTRIES-1:0]              permitNext;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    assign wordTag[i]  = entryAddr[i][ADDR_W-1:WORD_SHIFT];
    assign ioHit[i]    = (entryAddr[i] >= IO_BASE) && (entryAddr[i] <= IO_LAST);
    assign storeVec[i] = strobes[i].isStore;
  end

  // hazard[i][j]: older store j either has no address yet or shares i's word.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp_row
    for (genvar j = 0; j < ENTRIES; j++) begin : g_cmp_col
      assign hazard[i][j] = olderMask[i][j] && storeVec[j] &&
                            (!entryAddrOk[j] || (wordTag[j] == wordTag[i]));
    end
    assign blocked[i] = |hazard[i];
    assign permitNext[i] = entryAddrOk[i] &&
      (strobes[i].isHead ? (strobes[i].isLoad || strobes[i].isStore)
                         : (strobes[i].isLoad && !ioHit[i] && !blocked[i]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) issueOk <= '0;
    else       issueOk <= permitNext;
  end

endmodule

// File: rtl/memOrderGate.sv
module memOrderGate
  import memorder_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W = 32,
  parameter int WORD_SHIFT = 3,
  parameter logic [ADDR_W-1:0] IO_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] IO_LAST = 32'h4FFF_FFFF,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ENTRIES-1:0][1:0]        entryOp,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] entryAddr,
  input  logic [ENTRIES-1:0]             entryAddrOk,
  input  logic [IDX_W-1:0]               headPtr,
  output logic [ENTRIES-1:0]             issueOk
);

  entryStrobe_t [ENTRIES-1:0]      strobes;
  logic [ENTRIES-1:0][ENTRIES-1:0] olderMask;

  memOrderCtrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .entryOp   (entryOp),
    .headPtr   (headPtr),
    .strobes   (strobes),
    .olderMask (olderMask)
  );

  memOrderPath #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .WORD_SHIFT(WORD_SHIFT),
    .IO_BASE(IO_BASE), .IO_LAST(IO_LAST)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .olderMask   (olderMask),
    .entryAddr   (entryAddr),
    .entryAddrOk (entryAddrOk),
    .issueOk     (issueOk)
  );

endmodule

// File: rtl/memOrderGate_chk.sv
module memOrderGate_chk #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] IO_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] IO_LAST = 32'h4FFF_FFFF,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input logic                           clk,
  input logic                           rstN,
  input logic [ENTRIES-1:0][1:0]        entryOp,
  input logic [ENTRIES-1:0][ADDR_W-1:0] entryAddr,
  input logic [ENTRIES-1:0]             entryAddrOk,
  input logic [IDX_W-1:0]               headPtr,
  input logic [ENTRIES-1:0]             issueOk
);

  for (genvar k = 0; k < ENTRIES; k++) begin : g_chk
    p_empty_denied_r2: assert property (@(posedge clk) disable iff (!rstN)
      ($past(entryOp[k]) == 2'b00 || $past(entryOp[k]) == 2'b11) |-> !issueOk[k]);

    p_addr_unknown_r2: assert property (@(posedge clk) disable iff (!rstN)
      !$past(entryAddrOk[k]) |-> !issueOk[k]);

    p_head_granted_r3: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(headPtr) == IDX_W'(k) && $past(entryAddrOk[k]) &&
       ($past(entryOp[k]) == 2'b01 || $past(entryOp[k]) == 2'b10)) |-> issueOk[k]);

    p_store_waits_r4: assert property (@(posedge clk) disable iff (!rstN)
      (issueOk[k] && $past(entryOp[k]) == 2'b10) |-> $past(headPtr) == IDX_W'(k));

    p_io_waits_r5: assert property (@(posedge clk) disable iff (!rstN)
      (issueOk[k] && $past(entryAddr[k]) >= IO_BASE && $past(entryAddr[k]) <= IO_LAST)
      |-> $past(headPtr) == IDX_W'(k));
  end

endmodule

bind memOrderGate memOrderGate_chk #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .IO_LAST(IO_LAST)
) u_chk (
  .clk(clk), .rstN(rstN), .entryOp(entryOp), .entryAddr(entryAddr),
  .entryAddrOk(entryAddrOk), .headPtr(headPtr), .issueOk(issueOk)
);

// File: tb/memOrderGate_tb.sv
module memOrderGate_tb;

  localparam int N = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [N-1:0][1:0]  op;
  logic [N-1:0][31:0] addr;
  logic [N-1:0]       aok;
  logic [2:0]         head;
  logic [N-1:0]       issueOk;

  int checks = 0;
  int errors = 0;

  logic [N-1:0] expQ[$];
  string        tagQ[$];

  always #2 clk = ~clk;  // 250 MHz

  memOrderGate u_dut (
    .clk(clk), .rstN(rstN), .entryOp(op), .entryAddr(addr),
    .entryAddrOk(aok), .headPtr(head), .issueOk(issueOk)
  );

  task automatic clearAll();
    op = '0; addr = '0; aok = '0; head = '0;
  endtask

  task automatic setEntry(input int idx, input logic [1:0] kind,
                          input logic [31:0] a, input logic ok);
    op[idx] = kind; addr[idx] = a; aok[idx] = ok;
  endtask

  // Driver: call right after a falling edge with the entries already set.
  task automatic apply(input logic [2:0] h, input logic [N-1:0] exp, input string tag);
    head = h;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: the result of inputs set before a rising edge is read 1 ns after it.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      logic [N-1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (issueOk !== e) begin
        errors++;
        $display("FAIL %s: issueOk=%b expected=%b", t, issueOk, e);
      end
    end
  end

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clearAll();
    repeat (2) @(negedge clk);
    checks++;
    if (issueOk !== '0) begin
      errors++;
      $display("FAIL R1: issueOk=%b expected=%b", issueOk, 8'h00);
    end
    rstN = 1'b1;
    @(negedge clk);

    clearAll();
    apply(3'd0, 8'h00, "R2 all empty");

    // Head store plus loads in different words.
    clearAll();
    setEntry(0, 2'b10, 32'h100, 1'b1);
    setEntry(1, 2'b01, 32'h200, 1'b1);
    setEntry(2, 2'b01, 32'h108, 1'b1);
    apply(3'd0, 8'b0000_0111, "R3/R8 head store, distinct words");

    // Same 8-byte word, different byte offset.
    setEntry(2, 2'b01, 32'h104, 1'b1);
    apply(3'd0, 8'b0000_0011, "R8 partial overlap blocks");

    // Store commits: its entry empties.
    setEntry(0, 2'b00, 32'h100, 1'b1);
    apply(3'd0, 8'b0000_0110, "R6 load freed after store commit");

    clearAll();
    setEntry(0, 2'b01, 32'h10, 1'b1);
    setEntry(1, 2'b10, 32'h0, 1'b0);
    setEntry(2, 2'b01, 32'h300, 1'b1);
    setEntry(3, 2'b01, 32'h400, 1'b0);
    apply(3'd0, 8'b0000_0001, "R7 unknown older store address");

    clearAll();
    setEntry(0, 2'b01, 32'h10, 1'b1);
    setEntry(1, 2'b10, 32'h800, 1'b1);
    setEntry(2, 2'b01, 32'h900, 1'b1);
    apply(3'd0, 8'b0000_0101, "R4 non-head store held");

    clearAll();
    setEntry(0, 2'b01, 32'h20, 1'b1);
    setEntry(1, 2'b01, 32'h4000_0000, 1'b1);
    setEntry(2, 2'b01, 32'h4FFF_FFF8, 1'b1);
    setEntry(3, 2'b01, 32'h3FFF_FFF8, 1'b1);
    setEntry(4, 2'b01, 32'h5000_0000, 1'b1);
    apply(3'd0, 8'b0001_1001, "R5 window bounds");

    clearAll();
    setEntry(1, 2'b01, 32'h4000_0010, 1'b1);
    setEntry(2, 2'b01, 32'h4000_0020, 1'b1);
    apply(3'd1, 8'b0000_0010, "R3 peripheral load at head");

    // Wrap: head at 6, entries 6,7,0,1 in age order, 5 youngest.
    clearAll();
    setEntry(6, 2'b01, 32'h10, 1'b1);
    setEntry(7, 2'b10, 32'h2000, 1'b1);
    setEntry(0, 2'b01, 32'h2004, 1'b1);
    setEntry(1, 2'b01, 32'h3000, 1'b1);
    setEntry(5, 2'b10, 32'h3000, 1'b1);
    apply(3'd6, 8'h42, "R9 wrapped age order");

    // Same contents without wrap.
    apply(3'd0, 8'h43, "R6/R9 younger store ignored");

    clearAll();
    setEntry(7, 2'b10, 32'h4000_0000, 1'b1);
    setEntry(0, 2'b01, 32'h4000_0000, 1'b1);
    apply(3'd7, 8'h80, "R3 peripheral store at head");

    clearAll();
    setEntry(0, 2'b11, 32'h10, 1'b1);
    setEntry(1, 2'b01, 32'h10, 1'b1);
    apply(3'd0, 8'b0000_0010, "R2 reserved code at head");

    clearAll();
    setEntry(0, 2'b01, 32'h10, 1'b0);
    apply(3'd0, 8'h00, "R2 head address unknown");

    // R10: same inputs one edge later still give the registered result.
    clearAll();
    setEntry(3, 2'b01, 32'h30, 1'b1);
    apply(3'd3, 8'b0000_1000, "R10 one-cycle latency");
    clearAll();
    apply(3'd3, 8'h00, "R10 result follows input change");

    // Mid-run reset with a granting input present.
    setEntry(3, 2'b01, 32'h30, 1'b1);
    @(posedge clk);
    #1;
    rstN = 1'b0;
    #1;
    checks++;
    if (issueOk !== '0) begin
      errors++;
      $display("FAIL R1 mid-run reset: issueOk=%b expected=%b", issueOk, 8'h00);
    end
    @(negedge clk);
    checks++;
    if (issueOk !== '0) begin
      errors++;
      $display("FAIL R1 reset held: issueOk=%b expected=%b", issueOk, 8'h00);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule